// File: doc/BRIEF.md
# Halfword Signed Multiply-Accumulate Unit

This datapath serves the signed DSP multiply group of a processor core. It takes operand values that have already been read from the register file and works out one of five results. Three of them multiply two signed 16-bit halves. The other two multiply a full signed 32-bit word by a signed 16-bit half and keep product bits 47:16. The accumulating forms add a 32-bit or a 64-bit accumulator to the product.

A one-cycle `start` launches an operation. The unit answers with a one-cycle `done` strobe and a registered result. When a 32-bit accumulate overflows as a signed addition, the unit raises a one-cycle request that sets the core's sticky overflow flag. That request can only ever set the flag, never clear it. The 64-bit accumulate form needs one more cycle than the other forms.

Top module: `hmac_unit`

## Requirements
- R1: With `op` = 0, the unit forms the signed 16x16 product of two halves. `sel_a_hi` picks the half of `src_a` (1 picks bits 31:16, 0 picks bits 15:0), and `sel_b_hi` picks the half of `src_b` the same way. `result[31:0]` is the 32-bit signed product and `result[63:32]` is zero.
- R2: With `op` = 1, `result[31:0]` is the R1 product plus `acc_lo`, wrapped modulo 2^32, and `result[63:32]` is zero.
- R3: With `op` = 1 or 3, `ovf_set` is 1 in the `done` cycle exactly when the two addends have the same sign and the 32-bit sum has the opposite sign. The wrapped sum is still the result.
- R4: With `op` = 2, `result[31:0]` is bits 47:16 of signed `src_a` times the signed half of `src_b` chosen by `sel_b_hi`. `sel_a_hi` has no effect, and `result[63:32]` is zero.
- R5: With `op` = 3, `result[31:0]` is the R4 value plus `acc_lo`, wrapped modulo 2^32, and `result[63:32]` is zero.
- R6: With `op` = 4, the R1 product is sign-extended to 64 bits and added to {`acc_hi`,`acc_lo`}. `result` is the 64-bit sum, wrapped modulo 2^64.
- R7: With `op` = 0, 2 or 4, `ovf_set` stays 0. This holds even when the 64-bit sum overflows as a signed value.
- R8: `done` is a one-cycle pulse. For every `op` except 4 it comes at the first clock edge after the edge that takes `start`. For `op` = 4 it comes at the second edge. `ovf_set` is never 1 without `done`.
- R9: A `start` that arrives while an `op` = 4 operation waits for its second edge is ignored. It produces no `done` and does not change the result.
- R10: Synchronous reset clears `result`, `done` and `ovf_set` to zero.
- R11: `op` codes 5, 6 and 7 give `result` = 0, `ovf_set` = 0 and `done` one edge after `start`.
- R12: `result` holds its value while `done` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch an operation this cycle |
| op | input | 3 | Operation code (0..4, 5..7 reserved) |
| sel_a_hi | input | 1 | Pick upper half of `src_a` |
| sel_b_hi | input | 1 | Pick upper half of `src_b` |
| src_a | input | 32 | First multiply operand |
| src_b | input | 32 | Second multiply operand |
| acc_lo | input | 32 | 32-bit accumulator, or low word of the 64-bit one |
| acc_hi | input | 32 | High word of the 64-bit accumulator |
| result | output | 64 | Registered result |
| ovf_set | output | 1 | One-cycle request to set the sticky overflow flag |
| done | output | 1 | Result-valid strobe |

## Verification
Results of operation codes 0 to 3 and of the reserved codes are due one edge after `start`. The 64-bit accumulate result is due two edges after `start`, and for that code the bench also confirms that `done` is still low after the first edge. The bench drives inputs and samples on falling edges, so each check lands on the half cycle right after the edge that produces the value. One more sample after each `done` confirms that the strobe lasts a single cycle and that the result is held. A second `start` is placed in the wait cycle of a 64-bit accumulate to show that it is dropped.

// File: rtl/hmac_pkg.sv
package hmac_pkg;
  typedef enum logic [2:0] {
    OP_MUL_HH   = 3'd0,
    OP_MAC_HH   = 3'd1,
    OP_MUL_WH   = 3'd2,
    OP_MAC_WH   = 3'd3,
    OP_MAC_LONG = 3'd4
  } hmac_op_e;
endpackage

// File: rtl/hmac_halfsel.sv
// Selects one signed halfword of a data word.
module hmac_halfsel #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0]          word,
  input  logic                       pick_hi,
  output logic signed [DATA_W/2-1:0] half
);
  localparam int HALF_W = DATA_W / 2;

  always_comb begin
    if (pick_hi) half = $signed(word[DATA_W-1:HALF_W]);
    else         half = $signed(word[HALF_W-1:0]);
  end
endmodule

// File: rtl/hmac_mulcore.sv
// Half-by-half and word-by-half signed products.
module hmac_mulcore #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0]        src_a,
  input  logic [DATA_W-1:0]        src_b,
  input  logic                     sel_a_hi,
  input  logic                     sel_b_hi,
  output logic signed [DATA_W-1:0] prod_hh,
  output logic [DATA_W-1:0]        prod_wh
);
  localparam int HALF_W = DATA_W / 2;
  localparam int WIDE_W = DATA_W + HALF_W;

  logic signed [HALF_W-1:0] half_a;
  logic signed [HALF_W-1:0] half_b;
  logic signed [WIDE_W-1:0] wide_prod;

  hmac_halfsel #(.DATA_W(DATA_W)) u_sel_a (
    .word(src_a), .pick_hi(sel_a_hi), .half(half_a)
  );
  hmac_halfsel #(.DATA_W(DATA_W)) u_sel_b (
    .word(src_b), .pick_hi(sel_b_hi), .half(half_b)
  );

  // Sign-extending casts keep both multiplies signed at full width.
  assign prod_hh   = DATA_W'(half_a) * DATA_W'(half_b);
  assign wide_prod = WIDE_W'($signed(src_a)) * WIDE_W'(half_b);
  // Keep product bits WIDE_W-1 : HALF_W.
  assign prod_wh   = DATA_W'(wide_prod >>> HALF_W);
endmodule

// File: rtl/hmac_addovf.sv
// Wrapping adder with signed-overflow detect.
module hmac_addovf #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] sum,
  output logic         ovf
);
  always_comb begin
    sum = a + b;
    ovf = (a[W-1] == b[W-1]) && (sum[W-1] != a[W-1]);
  end
endmodule

// File: rtl/hmac_unit.sv
module hmac_unit
  import hmac_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic [2:0]          op,
  input  logic                sel_a_hi,
  input  logic                sel_b_hi,
  input  logic [DATA_W-1:0]   src_a,
  input  logic [DATA_W-1:0]   src_b,
  input  logic [DATA_W-1:0]   acc_lo,
  input  logic [DATA_W-1:0]   acc_hi,
  output logic [2*DATA_W-1:0] result,
  output logic                ovf_set,
  output logic                done
);
  localparam int LONG_W = 2 * DATA_W;

  hmac_op_e op_in;
  assign op_in = hmac_op_e'(op);

  logic signed [DATA_W-1:0] prod_hh;
  logic [DATA_W-1:0]        prod_wh;
  logic [DATA_W-1:0]        addend;
  logic [DATA_W-1:0]        acc_sum;
  logic                     acc_ovf;

  hmac_mulcore #(.DATA_W(DATA_W)) u_mul (
    .src_a(src_a), .src_b(src_b),
    .sel_a_hi(sel_a_hi), .sel_b_hi(sel_b_hi),
    .prod_hh(prod_hh), .prod_wh(prod_wh)
  );

  // One 32-bit adder serves both accumulate forms.
  assign addend = (op_in == OP_MAC_WH) ? prod_wh : prod_hh;

  hmac_addovf #(.W(DATA_W)) u_add (
    .a(addend), .b(acc_lo), .sum(acc_sum), .ovf(acc_ovf)
  );

  // Second beat of the long accumulate.
  logic                     pend;
  logic signed [DATA_W-1:0] lng_prod;
  logic [LONG_W-1:0]        lng_acc;
  logic [LONG_W-1:0]        lng_sum;
  hmac_op_e                 op_q;

  assign lng_sum = lng_acc + {{DATA_W{lng_prod[DATA_W-1]}}, lng_prod};

  always_ff @(posedge clk) begin
    if (rst) begin
      result   <= '0;
      ovf_set  <= 1'b0;
      done     <= 1'b0;
      pend     <= 1'b0;
      lng_prod <= '0;
      lng_acc  <= '0;
      op_q     <= OP_MUL_HH;
    end else begin
      done    <= 1'b0;
      ovf_set <= 1'b0;
      pend    <= 1'b0;
      if (pend) begin
        result <= lng_sum;
        done   <= 1'b1;
      end else if (start) begin
        op_q <= op_in;
        case (op_in)
          OP_MUL_HH: begin
            result <= {{DATA_W{1'b0}}, prod_hh};
            done   <= 1'b1;
          end
          OP_MUL_WH: begin
            result <= {{DATA_W{1'b0}}, prod_wh};
            done   <= 1'b1;
          end
          OP_MAC_HH, OP_MAC_WH: begin
            result  <= {{DATA_W{1'b0}}, acc_sum};
            ovf_set <= acc_ovf;
            done    <= 1'b1;
          end
          OP_MAC_LONG: begin
            pend     <= 1'b1;
            lng_prod <= prod_hh;
            lng_acc  <= {acc_hi, acc_lo};
          end
          default: begin
            result <= '0;
            done   <= 1'b1;
          end
        endcase
      end
    end
  end

  // R8: overflow request only together with the strobe
  p_ovf_with_done_r8: assert property (@(posedge clk) disable iff (rst)
    ovf_set |-> done);

  // R7: non-saturating forms never raise the request
  p_quiet_ops_r7: assert property (@(posedge clk) disable iff (rst)
    (done && op_q != OP_MAC_HH && op_q != OP_MAC_WH) |-> !ovf_set);

  // R8: short forms answer at the next edge
  p_short_latency_r8: assert property (@(posedge clk) disable iff (rst)
    (start && !pend && op_in != OP_MAC_LONG) |=> done);

  // R8: long form is silent at the first edge
  p_long_first_r8: assert property (@(posedge clk) disable iff (rst)
    (start && !pend && op_in == OP_MAC_LONG) |=> (pend && !done));

  // R8, R9: wait beat completes once and drops any new start
  p_long_second_r9: assert property (@(posedge clk) disable iff (rst)
    pend |=> (done && !pend));

  // R12: result changes only with the strobe
  p_hold_r12: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(result));
endmodule

// File: tb/hmac_unit_tb.sv
`timescale 1ns/1ps
module hmac_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [2:0]  op = 3'd0;
  logic        sel_a_hi = 1'b0;
  logic        sel_b_hi = 1'b0;
  logic [31:0] src_a = '0;
  logic [31:0] src_b = '0;
  logic [31:0] acc_lo = '0;
  logic [31:0] acc_hi = '0;
  logic [63:0] result;
  logic        ovf_set;
  logic        done;

  always #2 clk = ~clk;

  hmac_unit dut_i (
    .clk(clk), .rst(rst), .start(start), .op(op),
    .sel_a_hi(sel_a_hi), .sel_b_hi(sel_b_hi),
    .src_a(src_a), .src_b(src_b), .acc_lo(acc_lo), .acc_hi(acc_hi),
    .result(result), .ovf_set(ovf_set), .done(done)
  );

  int total = 0;
  int bad   = 0;
  bit finished = 1'b0;

  // {op, sel_a_hi, sel_b_hi, src_a, src_b, acc_lo, acc_hi, expected result, expected ovf}
  localparam int NV = 13;
  localparam logic [197:0] VECS [NV] = '{
    {3'd0, 1'b0, 1'b0, 32'h0003_FFFE, 32'h0005_0007, 32'h1234_5678, 32'h0, 64'h0000_0000_FFFF_FFF2, 1'b0},
    {3'd0, 1'b1, 1'b1, 32'h0003_FFFE, 32'h0005_0007, 32'h0,         32'h0, 64'h0000_0000_0000_000F, 1'b0},
    {3'd0, 1'b1, 1'b0, 32'h8000_0000, 32'h0000_8000, 32'h0,         32'h0, 64'h0000_0000_4000_0000, 1'b0},
    {3'd1, 1'b0, 1'b0, 32'h0000_0010, 32'h0000_0010, 32'h0000_0100, 32'h0, 64'h0000_0000_0000_0200, 1'b0},
    {3'd1, 1'b0, 1'b0, 32'h0000_4000, 32'h0000_4000, 32'h7000_0000, 32'h0, 64'h0000_0000_8000_0000, 1'b1},
    {3'd1, 1'b0, 1'b0, 32'h0000_8000, 32'h0000_7FFF, 32'h8000_0000, 32'h0, 64'h0000_0000_4000_8000, 1'b1},
    {3'd2, 1'b1, 1'b0, 32'h0001_0000, 32'h0000_0003, 32'h0,         32'h0, 64'h0000_0000_0000_0003, 1'b0},
    {3'd2, 1'b0, 1'b1, 32'hFFFF_FFFF, 32'h0001_0000, 32'h0,         32'h0, 64'h0000_0000_FFFF_FFFF, 1'b0},
    {3'd3, 1'b0, 1'b0, 32'h4000_0000, 32'h0000_7FFF, 32'h6000_0000, 32'h0, 64'h0000_0000_7FFF_C000, 1'b0},
    {3'd3, 1'b0, 1'b0, 32'h4000_0000, 32'h0000_7FFF, 32'h7000_0000, 32'h0, 64'h0000_0000_8FFF_C000, 1'b1},
    {3'd4, 1'b0, 1'b0, 32'h0000_FFFF, 32'h0000_0001, 32'h0000_0000, 32'h1, 64'h0000_0000_FFFF_FFFF, 1'b0},
    {3'd4, 1'b1, 1'b1, 32'h7FFF_0000, 32'h7FFF_0000, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 64'h8000_0000_3FFF_0000, 1'b0},
    {3'd5, 1'b1, 1'b1, 32'h1234_5678, 32'h1111_2222, 32'h0000_0001, 32'h0, 64'h0, 1'b0}
  };

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic string op_tag(input logic [2:0] o);
    case (o)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return "R4";
      3'd3: return "R5";
      3'd4: return "R6";
      default: return "R11";
    endcase
  endfunction

  task automatic run_vec(input logic [197:0] v);
    logic [63:0] exp_res;
    logic        exp_ovf;
    string       tag;
    exp_res = v[64:1];
    exp_ovf = v[0];
    tag = op_tag(v[197:195]);
    @(negedge clk);
    op       = v[197:195];
    sel_a_hi = v[194];
    sel_b_hi = v[193];
    src_a    = v[192:161];
    src_b    = v[160:129];
    acc_lo   = v[128:97];
    acc_hi   = v[96:65];
    start    = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (v[197:195] == 3'd4) begin
      chk(done == 1'b0, "R8 long first edge", 64'(done), 64'd0);
      @(negedge clk);
    end
    chk(done == 1'b1, "R8 done due", 64'(done), 64'd1);
    chk(result == exp_res, tag, result, exp_res);
    if (v[197:195] == 3'd1 || v[197:195] == 3'd3)
      chk(ovf_set == exp_ovf, "R3 overflow request", 64'(ovf_set), 64'(exp_ovf));
    else
      chk(ovf_set == 1'b0, "R7 no overflow request", 64'(ovf_set), 64'd0);
    @(negedge clk);
    chk(done == 1'b0, "R8 single-cycle done", 64'(done), 64'd0);
    chk(result == exp_res, "R12 result held", result, exp_res);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    chk(result == 64'd0, "R10 result", result, 64'd0);
    chk(done == 1'b0, "R10 done", 64'(done), 64'd0);
    chk(ovf_set == 1'b0, "R10 ovf_set", 64'(ovf_set), 64'd0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) run_vec(VECS[i]);

    // R12: result steady over idle cycles
    repeat (4) @(negedge clk);
    chk(result == 64'd0 && done == 1'b0, "R12 idle hold", result, 64'd0);

    // R9: start during the long wait cycle is dropped
    @(negedge clk);
    op = 3'd4; sel_a_hi = 1'b0; sel_b_hi = 1'b0;
    src_a = 32'h0000_FFFF; src_b = 32'h0000_0001;
    acc_lo = 32'h0; acc_hi = 32'h1;
    start = 1'b1;
    @(negedge clk);
    op = 3'd0; src_a = 32'h0000_0002; src_b = 32'h0000_0003;
    chk(done == 1'b0, "R9 wait cycle", 64'(done), 64'd0);
    @(negedge clk);
    start = 1'b0;
    chk(done == 1'b1, "R9 long done", 64'(done), 64'd1);
    chk(result == 64'h0000_0000_FFFF_FFFF, "R9 long result", result, 64'h0000_0000_FFFF_FFFF);
    @(negedge clk);
    chk(done == 1'b0, "R9 dropped start gives no done", 64'(done), 64'd0);
    chk(result == 64'h0000_0000_FFFF_FFFF, "R9 result untouched", result, 64'h0000_0000_FFFF_FFFF);

    // R10: reset after a result clears it
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(result == 64'd0, "R10 mid-run reset", result, 64'd0);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule